// File: doc/BRIEF.md
# Active Video Boundary Detector

The block watches a streamed video frame (pixel data plus horizontal and vertical sync) and finds the rectangle that holds picture content. A pixel counts as content in one of two ways. In level mode its value must be greater than a threshold. In gradient mode its step from the previous pixel must be greater than that threshold. Only pixels inside a programmable window are considered. The block reports four numbers for the frame:

- the earliest and latest horizontal extent over all lines, in pixel clocks from the hsync rising edge;
- the first content line, in hsyncs from the vsync rising edge;
- the line after the last content line.

Software writes a start pulse, and the block then measures exactly one frame. The first vsync rising edge after the start opens the measurement and the next one closes it. When the results are ready, a busy indication drops and a done pulse is given. A frame with no content is flagged rather than reported as a zero-sized picture.

Top module: `vid_edge_detect`

## Requirements
- R1: After reset, all four results are 0, and busy_o, done_o and no_data_o are 0.
- R2: A start_i pulse while idle raises busy_o. The frame between the next two vsync rising edges is measured. At the closing edge, done_o is high for exactly one cycle, busy_o falls in that same cycle, and the results change only then. A start_i pulse while busy_o is high has no effect, so no extra measurement follows.
- R3: Horizontal position 0 is the pixel in the clock where hsync_i is first seen high, and the position rises by 1 on each later clock. h_start_o is the smallest position of any content pixel in the frame.
- R4: h_end_o is one more than the largest position of any content pixel in the frame.
- R5: With grad_mode_i = 0, a pixel is content when pix_i > thresh_i, strictly; a value equal to the threshold is not content.
- R6: With grad_mode_i = 1, a pixel is content when |pix_i minus the pixel of the previous clock| > thresh_i.
- R7: Only pixels with win_x0_i <= position <= win_x1_i and win_y0_i <= line <= win_y1_i are judged. Content right of win_x1_i does not extend h_end_o.
- R8: Clocks after a vsync rising edge and before the next hsync rising edge belong to line 0, and each hsync rising edge advances the line by 1. v_start_o is the first line holding a content pixel.
- R9: v_end_o is one more than the last line holding content. Content-free lines between content lines do not change it. A content line that is still open when the closing vsync edge arrives is counted.
- R10: A line without content pixels leaves h_start_o and h_end_o as they would be without that line.
- R11: If the measured frame has no content pixel, all four results are 0 and no_data_o is 1. Otherwise no_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_i | input | DATA_W | Pixel value, one per clock |
| hsync_i | input | 1 | Horizontal sync, positive polarity |
| vsync_i | input | 1 | Vertical sync, positive polarity |
| win_x0_i | input | POS_W | Window left position, inclusive |
| win_x1_i | input | POS_W | Window right position, inclusive |
| win_y0_i | input | POS_W | Window top line, inclusive |
| win_y1_i | input | POS_W | Window bottom line, inclusive |
| thresh_i | input | DATA_W | Content threshold |
| grad_mode_i | input | 1 | 0 = level criterion, 1 = gradient criterion |
| start_i | input | 1 | Request one measurement |
| busy_o | output | 1 | Measurement requested or in progress |
| done_o | output | 1 | One-cycle pulse when results update |
| no_data_o | output | 1 | Last measured frame held no content |
| h_start_o | output | POS_W | Earliest content position |
| h_end_o | output | POS_W | Latest content position plus one |
| v_start_o | output | POS_W | First content line |
| v_end_o | output | POS_W | Last content line plus one |

## Verification
Two things can fall in the same clock: the closing of the last line of the frame and the closing of the frame itself. Both happen on the vsync rising edge when no hsync edge comes between the last line and the closing sync. The bench provokes this with a frame whose content reaches the final line, so the pending line must be folded into v_end_o in the same cycle that done_o fires; the expected value is that line plus one. A start pulse injected in the middle of that same measurement is judged by the absence of any further done pulse over a whole following frame.

// File: rtl/vbd_pkg.sv
package vbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS
  } meas_st_e;
endpackage

// File: rtl/vbd_sync_cnt.sv
module vbd_sync_cnt #(
  parameter int POS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic             hs_rise_o,
  output logic             vs_rise_o,
  output logic [POS_W-1:0] hpos_o,
  output logic [POS_W-1:0] vline_o,
  output logic [POS_W-1:0] vline_prev_o
);
  logic             hs_q, vs_q;
  logic [POS_W-1:0] hcnt_q, vl_q;

  assign hs_rise_o    = hsync_i & ~hs_q;
  assign vs_rise_o    = vsync_i & ~vs_q;
  assign hpos_o       = hs_rise_o ? '0 : hcnt_q;
  assign vline_prev_o = vl_q;

  always_comb begin
    if (vs_rise_o)                    vline_o = '0;
    else if (hs_rise_o && vl_q != '1) vline_o = vl_q + 1'b1;
    else                              vline_o = vl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      hcnt_q <= '0;
      vl_q   <= '0;
    end else begin
      hs_q   <= hsync_i;
      vs_q   <= vsync_i;
      hcnt_q <= (hpos_o == '1) ? hpos_o : hpos_o + 1'b1;
      vl_q   <= vline_o;
    end
  end
endmodule

// File: rtl/vbd_pix_qual.sv
module vbd_pix_qual #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_i,
  input  logic [DATA_W-1:0] thresh_i,
  input  logic              grad_mode_i,
  input  logic [POS_W-1:0]  hpos_i,
  input  logic [POS_W-1:0]  vline_i,
  input  logic [POS_W-1:0]  win_x0_i,
  input  logic [POS_W-1:0]  win_x1_i,
  input  logic [POS_W-1:0]  win_y0_i,
  input  logic [POS_W-1:0]  win_y1_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] prev_q, step;
  logic              is_data, in_win;

  assign step    = (pix_i >= prev_q) ? pix_i - prev_q : prev_q - pix_i;
  assign is_data = grad_mode_i ? (step > thresh_i) : (pix_i > thresh_i);
  assign in_win  = (hpos_i >= win_x0_i) && (hpos_i <= win_x1_i) &&
                   (vline_i >= win_y0_i) && (vline_i <= win_y1_i);
  assign hit_o   = is_data & in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pix_i;
  end
endmodule

// File: rtl/vbd_accum.sv
module vbd_accum #(
  parameter int POS_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             hit_i,
  input  logic             line_end_i,
  input  logic [POS_W-1:0] hpos_i,
  input  logic [POS_W-1:0] cur_line_i,
  output logic [POS_W-1:0] hmin_o,
  output logic [POS_W-1:0] hmax_o,
  output logic [POS_W-1:0] vmin_o,
  output logic [POS_W-1:0] vmax_o,
  output logic             found_o
);
  logic [POS_W-1:0] hmin_q, hmax_q, vmin_q, vmax_q, hpos_nx, line_nx;
  logic             vfound_q, line_has_q;

  assign hpos_nx = hpos_i + 1'b1;
  assign line_nx = cur_line_i + 1'b1;

  // close the still-open line combinationally for the final edge
  assign hmin_o  = hmin_q;
  assign hmax_o  = hmax_q;
  assign found_o = vfound_q | line_has_q;
  assign vmin_o  = vfound_q ? vmin_q : (line_has_q ? cur_line_i : '0);
  assign vmax_o  = line_has_q ? line_nx : vmax_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hmin_q     <= '1;
      hmax_q     <= '0;
      vmin_q     <= '0;
      vmax_q     <= '0;
      vfound_q   <= 1'b0;
      line_has_q <= 1'b0;
    end else if (clear_i) begin
      hmin_q     <= '1;
      hmax_q     <= '0;
      vmin_q     <= '0;
      vmax_q     <= '0;
      vfound_q   <= 1'b0;
      line_has_q <= 1'b0;
    end else if (en_i) begin
      if (hit_i) begin
        if (hpos_i < hmin_q)  hmin_q <= hpos_i;
        if (hpos_nx > hmax_q) hmax_q <= hpos_nx;
      end
      line_has_q <= line_end_i ? hit_i : (line_has_q | hit_i);
      if (line_end_i && line_has_q) begin
        if (!vfound_q) begin
          vmin_q   <= cur_line_i;
          vfound_q <= 1'b1;
        end
        vmax_q <= line_nx;
      end
    end
  end
endmodule

// File: rtl/vid_edge_detect.sv
module vid_edge_detect
  import vbd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [POS_W-1:0]  win_x0_i,
  input  logic [POS_W-1:0]  win_x1_i,
  input  logic [POS_W-1:0]  win_y0_i,
  input  logic [POS_W-1:0]  win_y1_i,
  input  logic [DATA_W-1:0] thresh_i,
  input  logic              grad_mode_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              no_data_o,
  output logic [POS_W-1:0]  h_start_o,
  output logic [POS_W-1:0]  h_end_o,
  output logic [POS_W-1:0]  v_start_o,
  output logic [POS_W-1:0]  v_end_o
);
  meas_st_e         st_q;
  logic             hs_rise, vs_rise, hit, en, clear, line_end, found, fin;
  logic [POS_W-1:0] hpos, vline, vline_prev, hmin, hmax, vmin, vmax;

  vbd_sync_cnt #(.POS_W(POS_W)) u_sync (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .hs_rise_o(hs_rise), .vs_rise_o(vs_rise),
    .hpos_o(hpos), .vline_o(vline), .vline_prev_o(vline_prev)
  );

  vbd_pix_qual #(.DATA_W(DATA_W), .POS_W(POS_W)) u_qual (
    .clk_i, .rst_ni, .pix_i, .thresh_i, .grad_mode_i,
    .hpos_i(hpos), .vline_i(vline),
    .win_x0_i, .win_x1_i, .win_y0_i, .win_y1_i,
    .hit_o(hit)
  );

  assign en       = (st_q == ST_MEAS) & ~vs_rise;
  assign clear    = (st_q == ST_ARM) & vs_rise;
  assign line_end = en & hs_rise;
  assign fin      = (st_q == ST_MEAS) & vs_rise;

  vbd_accum #(.POS_W(POS_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(clear), .en_i(en), .hit_i(hit),
    .line_end_i(line_end), .hpos_i(hpos), .cur_line_i(vline_prev),
    .hmin_o(hmin), .hmax_o(hmax), .vmin_o(vmin), .vmax_o(vmax), .found_o(found)
  );

  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      done_o    <= 1'b0;
      no_data_o <= 1'b0;
      h_start_o <= '0;
      h_end_o   <= '0;
      v_start_o <= '0;
      v_end_o   <= '0;
    end else begin
      done_o <= fin;
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_ARM;
        ST_ARM:  if (vs_rise) st_q <= ST_MEAS;
        ST_MEAS: if (vs_rise) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (fin) begin
        no_data_o <= ~found;
        h_start_o <= found ? hmin : '0;
        h_end_o   <= found ? hmax : '0;
        v_start_o <= found ? vmin : '0;
        v_end_o   <= found ? vmax : '0;
      end
    end
  end
endmodule

// File: rtl/vbd_checker.sv
module vbd_checker #(
  parameter int POS_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             no_data_o,
  input logic [POS_W-1:0] h_start_o,
  input logic [POS_W-1:0] h_end_o,
  input logic [POS_W-1:0] v_start_o,
  input logic [POS_W-1:0] v_end_o,
  input logic [POS_W-1:0] win_x0_i,
  input logic [POS_W-1:0] win_x1_i
);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_hold_results_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(h_start_o) && $stable(h_end_o) &&
                 $stable(v_start_o) && $stable(v_end_o) && $stable(no_data_o)));

  p_h_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !no_data_o) |-> (h_end_o > h_start_o));

  p_v_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !no_data_o) |-> (v_end_o > v_start_o));

  p_in_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !no_data_o) |->
      (h_start_o >= win_x0_i && {1'b0, h_end_o} <= {1'b0, win_x1_i} + 1'b1));

  p_empty_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_data_o |-> (h_start_o == '0 && h_end_o == '0 &&
                   v_start_o == '0 && v_end_o == '0));
endmodule

bind vid_edge_detect vbd_checker #(.POS_W(POS_W)) u_vbd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .no_data_o(no_data_o), .h_start_o(h_start_o), .h_end_o(h_end_o),
  .v_start_o(v_start_o), .v_end_o(v_end_o),
  .win_x0_i(win_x0_i), .win_x1_i(win_x1_i)
);

// File: tb/tb_vid_edge_detect.sv
module tb_vid_edge_detect;
  localparam int DATA_W = 8;
  localparam int POS_W  = 12;
  localparam int HT     = 40;
  localparam int NL     = 12;

  typedef struct {
    int hs, he, vs, ve;
    bit nd;
  } exp_t;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic [DATA_W-1:0] pix = '0, thr = '0;
  logic              hsync = 1'b0, vsync = 1'b0, grad = 1'b0, start = 1'b0;
  logic [POS_W-1:0]  wx0 = '0, wx1 = '1, wy0 = '0, wy1 = '1;
  logic              busy, done, no_data;
  logic [POS_W-1:0]  h_start, h_end, v_start, v_end;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  exp_t exp_q[$];

  // two content rectangles on a flat background
  int bg;
  int ax0, ax1, ay0, ay1, av;
  int bx0, bx1, by0, by1, bv;

  always #5 clk = ~clk;

  vid_edge_detect #(.DATA_W(DATA_W), .POS_W(POS_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix), .hsync_i(hsync), .vsync_i(vsync),
    .win_x0_i(wx0), .win_x1_i(wx1), .win_y0_i(wy0), .win_y1_i(wy1),
    .thresh_i(thr), .grad_mode_i(grad), .start_i(start),
    .busy_o(busy), .done_o(done), .no_data_o(no_data),
    .h_start_o(h_start), .h_end_o(h_end), .v_start_o(v_start), .v_end_o(v_end)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int pix_at(input int l, input int p);
    if (l >= ay0 && l <= ay1 && p >= ax0 && p <= ax1) return av;
    if (l >= by0 && l <= by1 && p >= bx0 && p <= bx1) return bv;
    return bg;
  endfunction

  // monitor: every done pulse must match the oldest expected item
  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R3 h_start", int'(h_start), e.hs);
        check("R4 h_end", int'(h_end), e.he);
        check("R8 v_start", int'(v_start), e.vs);
        check("R9 v_end", int'(v_end), e.ve);
        check("R11 no_data", int'(no_data), int'(e.nd));
        check("R2 busy falls with done", int'(busy), 0);
      end
    end
  end

  task automatic vs_pulse();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      vsync = 1'b1; hsync = 1'b0; pix = '0;
    end
    @(negedge clk);
    vsync = 1'b0;
  endtask

  // drives one measured frame and models the expected result on the way
  task automatic run_frame(input bit do_start, input bit late_start, input bit expect_done);
    exp_t e;
    int prev, v, d;
    bit any;
    e.hs = 1 << 30; e.he = -1; e.vs = -1; e.ve = 0; e.nd = 1;
    if (do_start) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check("R2 busy after start", int'(busy), 1);
    end
    vs_pulse();
    prev = 0;
    for (int l = 1; l <= NL; l++) begin
      any = 0;
      for (int p = 0; p < HT; p++) begin
        @(negedge clk);
        v = pix_at(l, p);
        hsync = (p < 2);
        pix = v[DATA_W-1:0];
        start = (late_start && l == 6 && p == 3);
        if (l == 5 && p == 7 && expect_done) check("R2 busy while measuring", int'(busy), 1);
        d = grad ? ((v > prev ? v - prev : prev - v) > int'(thr)) : (v > int'(thr));
        if (d && p >= int'(wx0) && p <= int'(wx1) && l >= int'(wy0) && l <= int'(wy1)) begin
          any = 1;
          if (p < e.hs) e.hs = p;
          if (p + 1 > e.he) e.he = p + 1;
        end
        prev = v;
      end
      if (any) begin
        if (e.vs < 0) e.vs = l;
        e.ve = l + 1;
        e.nd = 0;
      end
    end
    if (e.nd) begin e.hs = 0; e.he = 0; e.vs = 0; e.ve = 0; end
    if (expect_done) exp_q.push_back(e);
    vs_pulse();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 no_data", int'(no_data), 0);
    check("R1 h_start", int'(h_start), 0);
    check("R1 h_end", int'(h_end), 0);
    check("R1 v_start", int'(v_start), 0);
    check("R1 v_end", int'(v_end), 0);

    // R5 level mode, full window, dim background below threshold
    bg = 10; thr = 8'd50; grad = 1'b0;
    ax0 = 5; ax1 = 20; ay0 = 3; ay1 = 7; av = 200;
    bx0 = 0; bx1 = -1; by0 = 99; by1 = 0; bv = 0;
    run_frame(1, 0, 1);

    // R7 window clips both axes
    wx0 = 12'd8; wx1 = 12'd15; wy0 = 12'd4; wy1 = 12'd10;
    run_frame(1, 0, 1);
    wx0 = '0; wx1 = '1; wy0 = '0; wy1 = '1;

    // R6 gradient mode: both rectangle edges are content
    bg = 0; thr = 8'd30; grad = 1'b1;
    ax0 = 10; ax1 = 25; ay0 = 2; ay1 = 9; av = 100;
    run_frame(1, 0, 1);

    // R5 value equal to threshold is not content -> R11 no-data
    bg = 0; thr = 8'd200; grad = 1'b0; av = 200;
    run_frame(1, 0, 1);

    // R10 blank lines between blocks, R9 content on the final line,
    // plus R2 start pulse while busy
    bg = 0; thr = 8'd50; grad = 1'b0;
    ax0 = 12; ax1 = 14; ay0 = 2; ay1 = 3; av = 90;
    bx0 = 6; bx1 = 30; by0 = 9; by1 = NL; bv = 90;
    run_frame(1, 1, 1);

    // R2 ignored start: a whole frame follows with no done pulse
    run_frame(0, 0, 0);
    check("R2 idle after ignored start", int'(busy), 0);
    check("R2 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end
endmodule